// File: doc/BRIEF.md
# Way-Chopping Cache Tag Controller

This block is the tag and replacement controller of an 8-way set-associative cache whose active associativity can be cut at run time. Each set is held as one combined entry that packs the tags, the 2-bit line states and the pseudo-LRU tree bits of all its ways. A lookup is accepted every cycle and answers one cycle later with hit or miss, the way that hit (or was filled) and the victim way chosen from the set as it stood before the access.

A configuration input asks for a number of enabled ways. The request is clamped to 2, 4 or 8. Growing takes effect on the next cycle. Shrinking starts a sweep over every set and every way that is being turned off. The sweep handles one line per cycle, reports modified lines on a writeback port and invalidates every line it visits. Lookups are held off while the sweep runs. Only after it finishes do the disabled ways drop out of the enable vector and raise their power-down outputs. The data array and its datapath sit outside this block.

Top module: `waychop_tag_ctrl`

## Requirements
- R1: A request is accepted in a cycle where `req_valid` and `req_ready` are both high. Its response shows `rsp_valid` high in the next cycle. Requests on consecutive cycles each get a response, with no idle cycle between them.
- R2: `rsp_hit` is 1 only when an enabled way of the addressed set holds a non-invalid line with a matching tag. `rsp_way` then gives that way. A write hit marks the line modified.
- R3: On a miss, an enabled way in the invalid state is preferred as victim, the lowest index first. The victim receives the tag, and `rsp_way` equals the victim. A read fill gets state shared (01) when `req_shared` is 1 and exclusive (10) when it is 0. A write fill gets modified (11). Invalid is 00.
- R4: When every enabled way is valid, the victim comes from a 7-bit tree kept per set, cleared at reset. Node 0 picks the half: 0 means ways 0-3. Node 1 or node 2 picks the pair within the lower or upper half. Nodes 3 to 6 pick within the pairs (0,1), (2,3), (4,5) and (6,7). A node value of 0 points at the lower index. Each access sets the nodes on its way's path to point away from that way. With 4 ways enabled, node 0 reads as 0. With 2 ways enabled, node 1 also reads as 0. `rsp_victim` is computed before the access updates the tree.
- R5: `rsp_victim` and any allocated way always lie among the enabled ways.
- R6: The `cfg_ways` value is clamped as follows: 0, 1 or 2 gives 2 ways; 3 or 4 gives 4 ways; 5 or more gives 8 ways. Enabled ways are always ways 0 up to count-1. A value that clamps to the current count changes nothing.
- R7: Shrinking drops `req_ready` at once. It then visits sets in ascending order and, within each set, the ways being disabled in ascending order, one line per cycle. The sweep takes sets × (old − new) cycles. Every modified line it visits pulses `wb_valid` with its set, way and tag. Every visited line becomes invalid, so a later lookup of its tag misses.
- R8: `way_pwr_dn` stays unchanged during a sweep. It equals the complement of `way_en` once the sweep ends. Growing enables the added ways on the next cycle with no sweep.
- R9: After reset, all 8 ways are enabled, no way is powered down, no line is valid, `req_ready` is 1, and `rsp_valid` and `wb_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ways | input | WAY_W+1 | Requested number of enabled ways (clamped) |
| req_valid | input | 1 | Lookup request |
| req_write | input | 1 | Request is a write |
| req_shared | input | 1 | Fill a read miss in shared state |
| req_set | input | SET_W | Set index |
| req_tag | input | TAG_W | Tag to compare |
| req_ready | output | 1 | Requests are accepted this cycle |
| rsp_valid | output | 1 | Response valid |
| rsp_hit | output | 1 | Response is a hit |
| rsp_way | output | WAY_W | Hit way, or filled way on a miss |
| rsp_victim | output | WAY_W | Victim chosen before the access |
| way_en | output | WAYS | Per-way enable |
| way_pwr_dn | output | WAYS | Per-way power-down |
| wb_valid | output | 1 | Sweep reports a modified line |
| wb_set | output | SET_W | Set of the reported line |
| wb_way | output | WAY_W | Way of the reported line |
| wb_tag | output | TAG_W | Tag of the reported line |

## Verification
The bench builds the block with 8 ways, 4 sets and 6-bit tags. This keeps every set filling up many times and every sweep short enough to log line by line. With only four sets, each shrink step (8→4, 4→2, 8→4) is checked against a full list of expected writebacks and an exact cycle count. A reference tree model predicts each victim after the sets fill. Back-to-back request streams exercise the single-cycle throughput and the clamping of every class of `cfg_ways` value.

// File: rtl/tagc_pkg.sv
package tagc_pkg;

   typedef enum logic [1:0] {
      LS_INV = 2'b00,
      LS_SHR = 2'b01,
      LS_EXC = 2'b10,
      LS_MOD = 2'b11
   } line_st_e;

   // round a requested way count up to an allowed count (ways/4, ways/2, ways)
   function automatic int clamp_ways(input int req, input int ways);
      if (req <= ways / 4)      return ways / 4;
      else if (req <= ways / 2) return ways / 2;
      else                      return ways;
   endfunction

endpackage

// File: rtl/tagc_lookup.sv
module tagc_lookup
   import tagc_pkg::*;
#(
   parameter int WAYS  = 8,
   parameter int TAG_W = 20,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-1:0][TAG_W-1:0] tags,
   input  logic [WAYS-1:0][1:0]       st,
   input  logic [WAYS-1:0]            way_en,
   input  logic [TAG_W-1:0]           tag_in,
   output logic                       hit,
   output logic [WAY_W-1:0]           hit_way,
   output logic [WAYS-1:0]            valid_en
);

   logic [WAYS-1:0] match;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign valid_en[w] = way_en[w] && (st[w] != LS_INV);
      assign match[w]    = valid_en[w] && (tags[w] == tag_in);
   end

   always_comb begin
      hit     = |match;
      hit_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (match[w]) hit_way = WAY_W'(w);
      end
   end

endmodule

// File: rtl/tagc_victim.sv
module tagc_victim #(
   parameter int WAYS = 8,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic [WAYS-2:0]  lru,
   input  logic [WAYS-1:0]  valid_en,
   input  logic [WAYS-1:0]  way_en,
   input  logic [WAY_W-1:0] acc_way,
   output logic [WAY_W-1:0] victim,
   output logic [WAYS-2:0]  lru_nxt
);

   logic b0, b1, b2;
   logic found;

   always_comb begin
      // tree walk, upper levels forced low when the upper ways are disabled
      b0 = way_en[WAYS-1] ? lru[0] : 1'b0;
      b1 = way_en[WAYS/2-1] ? lru[1 + int'(b0)] : 1'b0;
      b2 = lru[3 + 2 * int'(b0) + int'(b1)];
      victim = {b0, b1, b2};
      found  = 1'b0;
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (way_en[w] && !valid_en[w]) begin
            victim = WAY_W'(w);
            found  = 1'b1;
         end
      end
   end

   always_comb begin
      lru_nxt = lru;
      lru_nxt[0] = ~acc_way[2];
      lru_nxt[1 + int'(acc_way[2])] = ~acc_way[1];
      lru_nxt[3 + 2 * int'(acc_way[2]) + int'(acc_way[1])] = ~acc_way[0];
   end

endmodule

// File: rtl/tagc_sweep.sv
module tagc_sweep #(
   parameter int SETS = 64,
   parameter int WAYS = 8,
   localparam int SET_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS),
   localparam int CNT_W = WAY_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] tgt_cnt,
   output logic [CNT_W-1:0] act_cnt,
   output logic             busy,
   output logic [SET_W-1:0] sw_set,
   output logic [WAY_W-1:0] sw_way
);

   logic [CNT_W-1:0] act_q, tgt_q;
   logic             busy_q;
   logic [SET_W-1:0] set_q;
   logic [WAY_W-1:0] way_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q  <= CNT_W'(WAYS);
         tgt_q  <= CNT_W'(WAYS);
         busy_q <= 1'b0;
         set_q  <= '0;
         way_q  <= '0;
      end else if (!busy_q) begin
         if (tgt_cnt < act_q) begin
            busy_q <= 1'b1;
            tgt_q  <= tgt_cnt;
            set_q  <= '0;
            way_q  <= tgt_cnt[WAY_W-1:0];
         end else if (tgt_cnt > act_q) begin
            act_q <= tgt_cnt;
         end
      end else begin
         if ({1'b0, way_q} == act_q - 1'b1) begin
            way_q <= tgt_q[WAY_W-1:0];
            if (set_q == SET_W'(SETS - 1)) begin
               busy_q <= 1'b0;
               act_q  <= tgt_q;
            end else begin
               set_q <= set_q + 1'b1;
            end
         end else begin
            way_q <= way_q + 1'b1;
         end
      end
   end

   assign act_cnt = act_q;
   assign busy    = busy_q;
   assign sw_set  = set_q;
   assign sw_way  = way_q;

   // R7
   sweep_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (({1'b0, way_q} >= tgt_q) && ({1'b0, way_q} < act_q)));

   // R6
   act_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q == CNT_W'(WAYS)) || (act_q == CNT_W'(WAYS/2)) || (act_q == CNT_W'(WAYS/4)));

endmodule

// File: rtl/waychop_tag_ctrl.sv
module waychop_tag_ctrl
   import tagc_pkg::*;
#(
   parameter int WAYS  = 8,
   parameter int SETS  = 64,
   parameter int TAG_W = 20,
   localparam int SET_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS),
   localparam int CNT_W = WAY_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cfg_ways,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic             req_shared,
   input  logic [SET_W-1:0] req_set,
   input  logic [TAG_W-1:0] req_tag,
   output logic             req_ready,
   output logic             rsp_valid,
   output logic             rsp_hit,
   output logic [WAY_W-1:0] rsp_way,
   output logic [WAY_W-1:0] rsp_victim,
   output logic [WAYS-1:0]  way_en,
   output logic [WAYS-1:0]  way_pwr_dn,
   output logic             wb_valid,
   output logic [SET_W-1:0] wb_set,
   output logic [WAY_W-1:0] wb_way,
   output logic [TAG_W-1:0] wb_tag
);

   if (WAYS != 8) begin : g_bad_ways
      $error("waychop_tag_ctrl: tree replacement is built for 8 ways");
   end
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("waychop_tag_ctrl: SETS must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("waychop_tag_ctrl: TAG_W must be positive");
   end

   // one combined entry per set: replacement tree, states, tags
   typedef struct packed {
      logic [WAYS-2:0]            lru;
      logic [WAYS-1:0][1:0]       st;
      logic [WAYS-1:0][TAG_W-1:0] tag;
   } set_ent_t;

   set_ent_t ent_q [SETS];
   set_ent_t rd_ent, sw_ent;

   logic [CNT_W-1:0] tgt_cnt, act_cnt;
   logic             sw_busy;
   logic [SET_W-1:0] sw_set;
   logic [WAY_W-1:0] sw_way;
   logic             acc, hit;
   logic [WAY_W-1:0] hit_way, vict, acc_way;
   logic [WAYS-1:0]  valid_en;
   logic [WAYS-2:0]  lru_nxt;

   assign tgt_cnt = CNT_W'(clamp_ways(int'(cfg_ways), WAYS));

   for (genvar w = 0; w < WAYS; w++) begin : g_en
      assign way_en[w] = (CNT_W'(w) < act_cnt);
   end
   assign way_pwr_dn = ~way_en;

   assign req_ready = !sw_busy && !(tgt_cnt < act_cnt);
   assign acc       = req_valid && req_ready;
   assign rd_ent    = ent_q[req_set];
   assign sw_ent    = ent_q[sw_set];
   assign acc_way   = hit ? hit_way : vict;

   tagc_lookup #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lookup (
      .tags     (rd_ent.tag),
      .st       (rd_ent.st),
      .way_en   (way_en),
      .tag_in   (req_tag),
      .hit      (hit),
      .hit_way  (hit_way),
      .valid_en (valid_en)
   );

   tagc_victim #(.WAYS(WAYS)) u_victim (
      .lru      (rd_ent.lru),
      .valid_en (valid_en),
      .way_en   (way_en),
      .acc_way  (acc_way),
      .victim   (vict),
      .lru_nxt  (lru_nxt)
   );

   tagc_sweep #(.SETS(SETS), .WAYS(WAYS)) u_sweep (
      .clk     (clk),
      .rst_n   (rst_n),
      .tgt_cnt (tgt_cnt),
      .act_cnt (act_cnt),
      .busy    (sw_busy),
      .sw_set  (sw_set),
      .sw_way  (sw_way)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) ent_q[s] <= '0;
         rsp_valid  <= 1'b0;
         rsp_hit    <= 1'b0;
         rsp_way    <= '0;
         rsp_victim <= '0;
      end else begin
         rsp_valid <= acc;
         if (acc) begin
            rsp_hit    <= hit;
            rsp_way    <= acc_way;
            rsp_victim <= vict;
            ent_q[req_set].lru <= lru_nxt;
            if (hit) begin
               if (req_write) ent_q[req_set].st[hit_way] <= LS_MOD;
            end else begin
               ent_q[req_set].tag[vict] <= req_tag;
               ent_q[req_set].st[vict]  <= req_write  ? LS_MOD :
                                           req_shared ? LS_SHR : LS_EXC;
            end
         end
         if (sw_busy) ent_q[sw_set].st[sw_way] <= LS_INV;
      end
   end

   assign wb_valid = sw_busy && (sw_ent.st[sw_way] == LS_MOD);
   assign wb_set   = sw_set;
   assign wb_way   = sw_way;
   assign wb_tag   = sw_ent.tag[sw_way];

   // R1
   accept_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> rsp_valid);

   // R2
   hit_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_hit) |-> way_en[rsp_way]);

   // R5
   victim_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (way_en[rsp_victim] && way_en[rsp_way]));

   // R8
   pwrdn_after_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(way_pwr_dn & ~$past(way_pwr_dn))) |-> $past(sw_busy));

   // R7
   wb_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> !req_ready);

endmodule

// File: tb/waychop_tag_ctrl_bench.sv
module waychop_tag_ctrl_bench;

   localparam int CLK_P = 10;
   localparam int WAYS  = 8;
   localparam int SETS  = 4;
   localparam int TAG_W = 6;
   localparam int SET_W = 2;
   localparam int WAY_W = 3;
   localparam int CNT_W = 4;

   logic             clk = 1'b0;
   logic             rst_n;
   logic [CNT_W-1:0] cfg_ways;
   logic             req_valid, req_write, req_shared;
   logic [SET_W-1:0] req_set;
   logic [TAG_W-1:0] req_tag;
   logic             req_ready, rsp_valid, rsp_hit;
   logic [WAY_W-1:0] rsp_way, rsp_victim;
   logic [WAYS-1:0]  way_en, way_pwr_dn;
   logic             wb_valid;
   logic [SET_W-1:0] wb_set;
   logic [WAY_W-1:0] wb_way;
   logic [TAG_W-1:0] wb_tag;

   waychop_tag_ctrl #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_waychop_tag_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_ways(cfg_ways),
      .req_valid(req_valid), .req_write(req_write), .req_shared(req_shared),
      .req_set(req_set), .req_tag(req_tag), .req_ready(req_ready),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
      .rsp_victim(rsp_victim), .way_en(way_en), .way_pwr_dn(way_pwr_dn),
      .wb_valid(wb_valid), .wb_set(wb_set), .wb_way(wb_way), .wb_tag(wb_tag)
   );

   always #(CLK_P/2) clk = ~clk;

   int total = 0;
   int bad   = 0;

   // reference model of the set contents
   int       m_tag [SETS][WAYS];
   int       m_st  [SETS][WAYS];
   bit [6:0] m_lru [SETS];
   int       m_act;
   int       sv_tag [SETS][WAYS];

   bit pend;
   int p_hit, p_way, p_vic;

   task automatic chk(input bit ok, input string rq, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: got %0d expected %0d", rq, what, act, exp);
      end
   endtask

   function automatic int msk(input int n);
      return (1 << n) - 1;
   endfunction

   function automatic int clampw(input int c);
      if (c <= 2) return 2;
      if (c <= 4) return 4;
      return 8;
   endfunction

   function automatic int m_victim(input int s);
      int b0, b1, b2;
      for (int w = 0; w < m_act; w++) if (m_st[s][w] == 0) return w;
      b0 = (m_act == 8) ? int'(m_lru[s][0]) : 0;
      b1 = (m_act == 2) ? 0 : int'(m_lru[s][1 + b0]);
      b2 = int'(m_lru[s][3 + 2 * b0 + b1]);
      return 4 * b0 + 2 * b1 + b2;
   endfunction

   function automatic void m_touch(input int s, input int w);
      int hi, mid, lo;
      hi = w / 4; mid = (w / 2) % 2; lo = w % 2;
      m_lru[s][0] = (hi == 0);
      m_lru[s][1 + hi] = (mid == 0);
      m_lru[s][3 + 2 * hi + mid] = (lo == 0);
   endfunction

   task automatic sample_pending();
      if (pend) begin
         chk(rsp_valid == 1'b1, "R1", "rsp_valid", int'(rsp_valid), 1);
         chk(int'(rsp_hit) == p_hit, "R2", "rsp_hit", int'(rsp_hit), p_hit);
         chk(int'(rsp_way) == p_way, p_hit ? "R2" : "R3", "rsp_way", int'(rsp_way), p_way);
         chk(int'(rsp_victim) == p_vic, "R4", "rsp_victim", int'(rsp_victim), p_vic);
         chk(p_vic < m_act, "R5", "victim enabled", p_vic, m_act - 1);
         pend = 0;
      end
   endtask

   task automatic do_req(input bit wr, input bit sh, input int s, input int t);
      int hw, vic, way;
      @(negedge clk);
      sample_pending();
      chk(req_ready == 1'b1, "R1", "req_ready", int'(req_ready), 1);
      hw = -1;
      for (int w = 0; w < m_act; w++)
         if (m_st[s][w] != 0 && m_tag[s][w] == t) hw = w;
      vic = m_victim(s);
      way = (hw >= 0) ? hw : vic;
      req_valid  = 1'b1;
      req_write  = wr;
      req_shared = sh;
      req_set    = SET_W'(s);
      req_tag    = TAG_W'(t);
      pend  = 1;
      p_hit = (hw >= 0);
      p_way = way;
      p_vic = vic;
      m_touch(s, way);
      if (hw >= 0) begin
         if (wr) m_st[s][way] = 3;
      end else begin
         m_tag[s][way] = t;
         m_st[s][way]  = wr ? 3 : (sh ? 1 : 2);
      end
   endtask

   task automatic flush();
      @(negedge clk);
      sample_pending();
      req_valid = 1'b0;
   endtask

   task automatic do_cfg(input int c);
      int tgt, old, n, idx, cyc;
      int e_set [64], e_way [64], e_tag [64];
      bit fin;
      tgt = clampw(c);
      old = m_act;
      @(negedge clk);
      cfg_ways = CNT_W'(c);
      #1;
      if (tgt < old) begin
         chk(req_ready == 1'b0, "R7", "ready drops on shrink", int'(req_ready), 0);
         n = 0;
         for (int s = 0; s < SETS; s++)
            for (int w = tgt; w < old; w++)
               if (m_st[s][w] == 3) begin
                  e_set[n] = s; e_way[n] = w; e_tag[n] = m_tag[s][w]; n++;
               end
         idx = 0; cyc = 0; fin = 0;
         while (!fin) begin
            @(negedge clk);
            if (req_ready) fin = 1;
            else begin
               cyc++;
               chk(int'(way_pwr_dn) == (255 & ~msk(old)), "R8", "pwr_dn held in sweep",
                   int'(way_pwr_dn), 255 & ~msk(old));
               if (wb_valid) begin
                  if (idx < n) begin
                     chk(int'(wb_set) == e_set[idx], "R7", "wb_set", int'(wb_set), e_set[idx]);
                     chk(int'(wb_way) == e_way[idx], "R7", "wb_way", int'(wb_way), e_way[idx]);
                     chk(int'(wb_tag) == e_tag[idx], "R7", "wb_tag", int'(wb_tag), e_tag[idx]);
                  end
                  idx++;
               end
            end
         end
         chk(idx == n, "R7", "writeback count", idx, n);
         chk(cyc == SETS * (old - tgt), "R7", "sweep cycles", cyc, SETS * (old - tgt));
         chk(int'(way_en) == msk(tgt), "R8", "way_en after sweep", int'(way_en), msk(tgt));
         chk(int'(way_pwr_dn) == (255 & ~msk(tgt)), "R8", "pwr_dn after sweep",
             int'(way_pwr_dn), 255 & ~msk(tgt));
         for (int s = 0; s < SETS; s++)
            for (int w = tgt; w < old; w++) m_st[s][w] = 0;
         m_act = tgt;
      end else if (tgt > old) begin
         @(negedge clk);
         chk(int'(way_en) == msk(tgt), "R8", "way_en after grow", int'(way_en), msk(tgt));
         chk(way_pwr_dn == 8'h00, "R8", "pwr_dn after grow", int'(way_pwr_dn), 0);
         chk(req_ready == 1'b1, "R6", "ready on grow", int'(req_ready), 1);
         m_act = tgt;
      end else begin
         chk(req_ready == 1'b1, "R6", "ready on same count", int'(req_ready), 1);
         @(negedge clk);
         chk(int'(way_en) == msk(old), "R6", "way_en unchanged", int'(way_en), msk(old));
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; cfg_ways = 4'd8; req_valid = 1'b0; req_write = 1'b0;
      req_shared = 1'b0; req_set = '0; req_tag = '0; pend = 0; m_act = 8;
      for (int s = 0; s < SETS; s++) begin
         m_lru[s] = '0;
         for (int w = 0; w < WAYS; w++) begin m_tag[s][w] = 0; m_st[s][w] = 0; end
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R9 reset state
      chk(way_en == 8'hFF, "R9", "way_en", int'(way_en), 255);
      chk(way_pwr_dn == 8'h00, "R9", "way_pwr_dn", int'(way_pwr_dn), 0);
      chk(req_ready == 1'b1, "R9", "req_ready", int'(req_ready), 1);
      chk(rsp_valid == 1'b0, "R9", "rsp_valid", int'(rsp_valid), 0);
      chk(wb_valid == 1'b0, "R9", "wb_valid", int'(wb_valid), 0);

      // R3 fill every way, back to back (R1), lowest invalid first
      for (int s = 0; s < SETS; s++)
         for (int k = 0; k < 8; k++) do_req(k % 2 == 1, k == 2 || k == 6, s, k + 1);
      // R2 hits in every way, a write hit upgrades way 2
      for (int s = 0; s < SETS; s++)
         for (int k = 0; k < 8; k++) do_req(k == 2, 1'b0, s, k + 1);
      // R4 misses on full sets follow the tree
      for (int j = 0; j < 5; j++)
         for (int s = 0; s < SETS; s++) do_req(j % 2 == 1, 1'b0, s, 20 + j);
      flush();

      // R6 R7 shrink 8 -> 4 via a value that clamps up
      for (int s = 0; s < SETS; s++)
         for (int w = 0; w < WAYS; w++) sv_tag[s][w] = m_tag[s][w];
      do_cfg(3);
      // R7 swept tags now miss; R5 victims stay in ways 0-3
      for (int s = 0; s < SETS; s++)
         for (int w = 4; w < 8; w++) do_req(w % 2 == 0, 1'b0, s, sv_tag[s][w]);
      for (int s = 0; s < SETS; s++) do_req(1'b1, 1'b0, s, 30 + s);
      flush();

      // R6 shrink 4 -> 2 with value 0
      do_cfg(0);
      for (int j = 0; j < 4; j++)
         for (int s = 0; s < SETS; s++) do_req(j % 2 == 1, j == 2, s, 40 + j);
      flush();

      // R8 grow to 8 with value 15, new fills use ways 2..7 first
      do_cfg(15);
      for (int j = 0; j < 7; j++)
         for (int s = 0; s < SETS; s++) do_req(1'b1, 1'b0, s, 50 + j);
      flush();

      // R6 value 6 clamps to 8: no change
      do_cfg(6);
      // R7 shrink 8 -> 4 with exact value, then grow with 5
      do_cfg(4);
      for (int s = 0; s < SETS; s++) do_req(1'b0, 1'b0, s, 50 + s);
      flush();
      do_cfg(5);
      for (int s = 0; s < SETS; s++) do_req(1'b0, 1'b1, s, 60 + s);
      flush();

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule